// File: doc/BRIEF.md
# Paged DMA Address and Count Engine

This block runs the address and count side of a small set of DMA channels. Each channel has an 8-bit page, a 16-bit current address, a 16-bit remaining count and a transfer kind. A register-file load port writes these values. When a device raises its request and the channel is not masked, the engine asks the bus owner for the bus. When the grant arrives it performs one single-mode transfer. During that transfer it acknowledges the device, drives a 24-bit physical address and a direction flag, and then advances the address and steps the count down.

Byte channels place the page above the 16-bit address. Word channels shift the 16-bit address up by one bit, ignore page bit 0 and force address bit 0 low. In both cases the page is never carried into, so a run of transfers wraps inside its 64K or 128K window. Which channels are word channels is fixed by a parameter.

The count is loaded as the number of transfers minus one. On the transfer that moves the count from zero down past zero, the engine raises a one-cycle terminal-count pulse, latches a per-channel done flag and masks the channel. A channel set to the cascade kind generates no address. It only forwards its request upstream and returns the grant to the device as its acknowledge.

Top module: `dma_page_engine`

## Requirements
- R1: A loaded count C gives exactly C+1 transfers before the channel stops. C = 0 gives one transfer.
- R2: On a byte channel the physical address during a transfer is {page[7:0], addr[15:0]}.
- R3: On a word channel (WORD_MAP bit set; default channels 2 and 3) the physical address is {page[7:1], addr[15:0], 1'b0}. Page bit 0 has no effect and phys_addr[0] is always 0.
- R4: The 16-bit address wraps from 0xFFFF to 0x0000 with the page unchanged.
- R5: Each grant cycle serves one transfer. hold_req falls between two transfers, and the address advances by one after each transfer.
- R6: Kind encoding: 2'b01 moves data from the device into memory (mem_write=1), 2'b10 moves data from memory to the device (mem_write=0), 2'b11 is cascade, 2'b00 is verify (mem_write=0).
- R7: A channel whose mask bit is 1 raises no hold_req, no acknowledge and no transfer.
- R8: A cascade channel drives hold_req from its dreq and drives its dack from hold_ack, with addr_valid staying 0.
- R9: When several unmasked channels request together, the lowest-numbered channel is served first.
- R10: On the last transfer tc_pulse is high for exactly that cycle. Afterwards the channel's tc_status bit and mask bit read 1. Loading the channel clears its tc_status bit.
- R11: An acknowledge is given only while hold_ack is high. While hold_ack is withheld no transfer occurs.
- R12: After reset hold_req, dack and tc_status are 0 and every mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Load strobe for one channel's settings |
| ld_chan | input | 2 | Channel being loaded |
| ld_page | input | 8 | Page value |
| ld_addr | input | 16 | Start address (words on word channels) |
| ld_count | input | 16 | Transfers minus one |
| ld_kind | input | 2 | Transfer kind (see R6) |
| mask_wr | input | 1 | Write strobe for the mask vector |
| mask_wdata | input | 4 | New mask vector, 1 = masked |
| dreq | input | 4 | Device requests |
| hold_ack | input | 1 | Bus grant from the bus owner |
| hold_req | output | 1 | Bus request to the bus owner |
| dack | output | 4 | Device acknowledges, one-hot or zero |
| addr_valid | output | 1 | A transfer happens this cycle |
| phys_addr | output | 24 | Physical address, zero when not valid |
| mem_write | output | 1 | 1 = write into memory this transfer |
| tc_pulse | output | 1 | Terminal-count pulse |
| tc_status | output | 4 | Per-channel done flags |
| mask_q | output | 4 | Current mask vector |

## Verification
With the grant held high, a request seen at a clock edge raises hold_req after that edge. The transfer cycle, with dack, addr_valid, phys_addr and tc_pulse, follows one edge later, and the mask and done flags change at the edge that ends the transfer. The cascade acknowledge and its hold_req follow dreq and hold_ack in the same cycle. The bench drives inputs on the falling edge and samples on the next falling edge. For multi-transfer runs it records every transfer cycle over a fixed window and compares the recorded list with the expected addresses, so that checks do not depend on the exact gap between transfers. Gaps of at least one idle cycle are checked separately.

// File: rtl/dma_page_pkg.sv
// Shared types for the paged DMA engine.
// Assumes: two-bit transfer kind codes as listed in the brief.
package dma_page_pkg;

    typedef enum logic [1:0] {
        XK_VERIFY   = 2'b00,
        XK_TO_MEM   = 2'b01,
        XK_FROM_MEM = 2'b10,
        XK_CASCADE  = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'b00,
        SQ_REQ  = 2'b01,
        SQ_XFER = 2'b10,
        SQ_CASC = 2'b11
    } seq_state_e;

endpackage

// File: rtl/dma_prio_pick.sv
// Fixed-priority picker: the lowest set request bit wins.
// Assumes: NCH >= 1; outputs are purely combinational.
module dma_prio_pick #(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CW-1:0]  idx
);

    // Scan from the top down so the lowest index is written last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = CW'(i);
            end
        end
    end

endmodule

// File: rtl/dma_chan_bank.sv
// Per-channel state: page, current address, remaining count, kind,
// mask bit and done flag. It forms each channel's physical address.
// Assumes: step fires at most once per cycle and only on the served
// channel; the page is never incremented.
module dma_chan_bank
    import dma_page_pkg::*;
#(
    parameter int             NCH      = 4,
    parameter int             PAGE_W   = 8,
    parameter int             OFS_W    = 16,
    parameter logic [NCH-1:0] WORD_MAP = 4'b1100,
    localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int PHYS_W = PAGE_W + OFS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_valid,
    input  logic [CW-1:0]         ld_chan,
    input  logic [PAGE_W-1:0]     ld_page,
    input  logic [OFS_W-1:0]      ld_addr,
    input  logic [OFS_W-1:0]      ld_count,
    input  logic [1:0]            ld_kind,
    input  logic                  mask_wr,
    input  logic [NCH-1:0]        mask_wdata,
    input  logic                  step,
    input  logic [CW-1:0]         step_chan,
    output logic [NCH-1:0]        mask_q,
    output logic [NCH-1:0]        tc_q,
    output logic [NCH-1:0]        last_q,
    output logic [NCH*2-1:0]      kind_flat,
    output logic [NCH*PHYS_W-1:0] phys_flat
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [PAGE_W-1:0] page_r;
        logic [OFS_W-1:0]  addr_r;
        logic [OFS_W-1:0]  cnt_r;
        logic [1:0]        kind_r;
        logic              mask_r;
        logic              tc_r;
        logic              ld_hit;
        logic              st_hit;
        logic              at_end;

        assign ld_hit = ld_valid && (ld_chan == CW'(i));
        assign st_hit = step && (step_chan == CW'(i));
        assign at_end = (cnt_r == '0);

        // Load the channel settings, or advance address and count after a transfer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                page_r <= '0;
                addr_r <= '0;
                cnt_r  <= '0;
                kind_r <= XK_VERIFY;
            end else if (ld_hit) begin
                page_r <= ld_page;
                addr_r <= ld_addr;
                cnt_r  <= ld_count;
                kind_r <= ld_kind;
            end else if (st_hit) begin
                addr_r <= addr_r + 1'b1;
                cnt_r  <= cnt_r - 1'b1;
            end
        end

        // Mask bit: starts set, written by software, set again at terminal count.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_r <= 1'b1;
            end else if (st_hit && at_end) begin
                mask_r <= 1'b1;
            end else if (mask_wr) begin
                mask_r <= mask_wdata[i];
            end
        end

        // Done flag: set at terminal count, cleared when the channel is reloaded.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tc_r <= 1'b0;
            end else if (ld_hit) begin
                tc_r <= 1'b0;
            end else if (st_hit && at_end) begin
                tc_r <= 1'b1;
            end
        end

        if (WORD_MAP[i]) begin : g_word
            assign phys_flat[i*PHYS_W +: PHYS_W] = {page_r[PAGE_W-1:1], addr_r, 1'b0};
        end else begin : g_byte
            assign phys_flat[i*PHYS_W +: PHYS_W] = {page_r, addr_r};
        end

        assign mask_q[i]         = mask_r;
        assign tc_q[i]           = tc_r;
        assign last_q[i]         = at_end;
        assign kind_flat[i*2 +: 2] = kind_r;
    end

endmodule

// File: rtl/dma_seq_fsm.sv
// Transfer sequencer: latches the picked channel, asks for the bus,
// performs one transfer per grant, or passes a cascade channel through.
// Assumes: the picker's result is valid in the idle state; the mask
// can change at any time and aborts a pending service.
module dma_seq_fsm
    import dma_page_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pick_any,
    input  logic [CW-1:0]    pick_idx,
    input  logic [NCH*2-1:0] kind_flat,
    input  logic [NCH-1:0]   mask_q,
    input  logic [NCH-1:0]   dreq,
    input  logic             hold_ack,
    output logic             hold_req,
    output logic [NCH-1:0]   dack,
    output logic             xfer_now,
    output logic [CW-1:0]    sel_chan
);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] sel_q, sel_d;
    logic [1:0]    pick_kind;
    logic          sel_masked;
    logic          sel_dreq;
    logic          casc_ack;
    logic [NCH-1:0] sel_onehot;

    assign pick_kind  = kind_flat[pick_idx*2 +: 2];
    assign sel_masked = mask_q[sel_q];
    assign sel_dreq   = dreq[sel_q];

    // Next-state choice for the service sequence.
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        case (state_q)
            SQ_IDLE: begin
                if (pick_any) begin
                    sel_d   = pick_idx;
                    state_d = (pick_kind == XK_CASCADE) ? SQ_CASC : SQ_REQ;
                end
            end
            SQ_REQ: begin
                if (sel_masked)    state_d = SQ_IDLE;
                else if (hold_ack) state_d = SQ_XFER;
            end
            SQ_XFER: begin
                if (sel_masked)    state_d = SQ_IDLE;
                else if (hold_ack) state_d = SQ_IDLE;
                else               state_d = SQ_REQ;
            end
            SQ_CASC: begin
                if (sel_masked || !sel_dreq) state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // State and selected-channel registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // One-hot decode of the selected channel.
    always_comb begin
        sel_onehot        = '0;
        sel_onehot[sel_q] = 1'b1;
    end

    assign xfer_now = (state_q == SQ_XFER) && hold_ack && !sel_masked;
    assign casc_ack = (state_q == SQ_CASC) && hold_ack && sel_dreq && !sel_masked;

    assign hold_req = (((state_q == SQ_REQ) || (state_q == SQ_XFER)) && !sel_masked) ||
                      ((state_q == SQ_CASC) && sel_dreq && !sel_masked);
    assign dack     = (xfer_now || casc_ack) ? sel_onehot : '0;
    assign sel_chan = sel_q;

endmodule

// File: rtl/dma_page_engine.sv
// Top of the paged DMA address and count engine. It joins the channel
// bank, the priority picker and the sequencer, and drives the
// per-transfer address, direction and terminal-count outputs.
// Assumes: single mode, incrementing addresses, no auto-init.
module dma_page_engine
    import dma_page_pkg::*;
#(
    parameter int             NCH      = 4,
    parameter int             PAGE_W   = 8,
    parameter int             OFS_W    = 16,
    parameter logic [NCH-1:0] WORD_MAP = 4'b1100,
    localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int PHYS_W = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [CW-1:0]     ld_chan,
    input  logic [PAGE_W-1:0] ld_page,
    input  logic [OFS_W-1:0]  ld_addr,
    input  logic [OFS_W-1:0]  ld_count,
    input  logic [1:0]        ld_kind,
    input  logic              mask_wr,
    input  logic [NCH-1:0]    mask_wdata,
    input  logic [NCH-1:0]    dreq,
    input  logic              hold_ack,
    output logic              hold_req,
    output logic [NCH-1:0]    dack,
    output logic              addr_valid,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              mem_write,
    output logic              tc_pulse,
    output logic [NCH-1:0]    tc_status,
    output logic [NCH-1:0]    mask_q
);

    logic [NCH-1:0]        last_q;
    logic [NCH*2-1:0]      kind_flat;
    logic [NCH*PHYS_W-1:0] phys_flat;
    logic                  pick_any;
    logic [CW-1:0]         pick_idx;
    logic                  xfer_now;
    logic [CW-1:0]         sel_chan;
    logic [NCH-1:0]        eligible;
    logic [1:0]            sel_kind;

    assign eligible = dreq & ~mask_q;

    dma_chan_bank #(
        .NCH(NCH), .PAGE_W(PAGE_W), .OFS_W(OFS_W), .WORD_MAP(WORD_MAP)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_chan(ld_chan), .ld_page(ld_page),
        .ld_addr(ld_addr), .ld_count(ld_count), .ld_kind(ld_kind),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .step(xfer_now), .step_chan(sel_chan),
        .mask_q(mask_q), .tc_q(tc_status), .last_q(last_q),
        .kind_flat(kind_flat), .phys_flat(phys_flat)
    );

    dma_prio_pick #(.NCH(NCH)) u_pick (
        .req(eligible), .any(pick_any), .idx(pick_idx)
    );

    dma_seq_fsm #(.NCH(NCH)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .pick_any(pick_any), .pick_idx(pick_idx),
        .kind_flat(kind_flat), .mask_q(mask_q),
        .dreq(dreq), .hold_ack(hold_ack),
        .hold_req(hold_req), .dack(dack),
        .xfer_now(xfer_now), .sel_chan(sel_chan)
    );

    assign sel_kind   = kind_flat[sel_chan*2 +: 2];
    assign addr_valid = xfer_now;
    assign phys_addr  = xfer_now ? phys_flat[sel_chan*PHYS_W +: PHYS_W] : '0;
    assign mem_write  = xfer_now && (sel_kind == XK_TO_MEM);
    assign tc_pulse   = xfer_now && last_q[sel_chan];

endmodule

// File: rtl/dma_page_engine_chk.sv
// Property checker for the paged DMA engine, attached by bind.
// Assumes: observes top-level ports only.
module dma_page_engine_chk #(
    parameter int             NCH      = 4,
    parameter int             PHYS_W   = 24,
    parameter logic [NCH-1:0] WORD_MAP = 4'b1100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_ack,
    input logic              hold_req,
    input logic [NCH-1:0]    dack,
    input logic              addr_valid,
    input logic [PHYS_W-1:0] phys_addr,
    input logic              tc_pulse,
    input logic [NCH-1:0]    tc_status,
    input logic [NCH-1:0]    mask_q
);

    // R11: an acknowledge needs the grant
    p_ack_needs_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack) |-> hold_ack);

    // R9: at most one channel acknowledged
    p_single_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    // R5: a transfer has an acknowledged channel and an active bus request
    p_xfer_has_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> ((|dack) && hold_req));

    // R7: no transfer on a masked channel
    p_no_masked_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> ((dack & mask_q) == '0));

    // R10: terminal count lasts one cycle and sits on a transfer
    p_tc_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);
    p_tc_on_xfer_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> addr_valid);

    // R10: the finished channel becomes masked and flagged
    p_tc_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> (((mask_q & $past(dack)) == $past(dack)) &&
                      ((tc_status & $past(dack)) == $past(dack))));

    // R3: word channels never drive an odd address
    p_word_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && ((dack & WORD_MAP) != '0)) |-> !phys_addr[0]);

endmodule

bind dma_page_engine dma_page_engine_chk #(
    .NCH(NCH), .PHYS_W(PHYS_W), .WORD_MAP(WORD_MAP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hold_ack(hold_ack), .hold_req(hold_req),
    .dack(dack), .addr_valid(addr_valid), .phys_addr(phys_addr),
    .tc_pulse(tc_pulse), .tc_status(tc_status), .mask_q(mask_q)
);

// File: tb/tb_dma_page_engine.sv
// Directed bench for the paged DMA engine, one task per scenario.
module tb_dma_page_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_chan = '0;
    logic [7:0]  ld_page = '0;
    logic [15:0] ld_addr = '0;
    logic [15:0] ld_count = '0;
    logic [1:0]  ld_kind = '0;
    logic        mask_wr = 1'b0;
    logic [3:0]  mask_wdata = '0;
    logic [3:0]  dreq = '0;
    logic        hold_ack = 1'b1;
    logic        hold_req;
    logic [3:0]  dack;
    logic        addr_valid;
    logic [23:0] phys_addr;
    logic        mem_write;
    logic        tc_pulse;
    logic [3:0]  tc_status;
    logic [3:0]  mask_q;

    int n_checks = 0;
    int n_errors = 0;

    // window capture
    int          w_nv;
    int          w_ntc;
    int          w_tc_at;
    bit          w_adjacent;
    bit          w_saw_req;
    logic [23:0] w_addr [8];
    logic [3:0]  w_dack [8];
    logic        w_mw   [8];

    dma_page_engine dut (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_chan(ld_chan), .ld_page(ld_page),
        .ld_addr(ld_addr), .ld_count(ld_count), .ld_kind(ld_kind),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .dreq(dreq), .hold_ack(hold_ack),
        .hold_req(hold_req), .dack(dack), .addr_valid(addr_valid),
        .phys_addr(phys_addr), .mem_write(mem_write), .tc_pulse(tc_pulse),
        .tc_status(tc_status), .mask_q(mask_q)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] byte_phys(input logic [7:0] pg, input logic [15:0] a);
        return {pg, a};
    endfunction

    function automatic logic [23:0] word_phys(input logic [7:0] pg, input logic [15:0] a);
        return {pg[7:1], a, 1'b0};
    endfunction

    task automatic load_ch(input logic [1:0] ch, input logic [7:0] pg,
                           input logic [15:0] a, input logic [15:0] c,
                           input logic [1:0] k);
        @(negedge clk);
        ld_valid = 1'b1; ld_chan = ch; ld_page = pg;
        ld_addr = a; ld_count = c; ld_kind = k;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic write_mask(input logic [3:0] m);
        @(negedge clk);
        mask_wr = 1'b1; mask_wdata = m;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    // Sample ncyc falling edges and record every transfer cycle.
    task automatic run_window(input int ncyc);
        bit prev_v = 1'b0;
        w_nv = 0; w_ntc = 0; w_tc_at = -1; w_adjacent = 1'b0; w_saw_req = 1'b0;
        for (int k = 0; k < 8; k++) begin
            w_addr[k] = '0; w_dack[k] = '0; w_mw[k] = 1'b0;
        end
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (hold_req) w_saw_req = 1'b1;
            if (addr_valid) begin
                if (prev_v) w_adjacent = 1'b1;
                if (w_nv < 8) begin
                    w_addr[w_nv] = phys_addr;
                    w_dack[w_nv] = dack;
                    w_mw[w_nv]   = mem_write;
                end
                if (tc_pulse) begin
                    w_ntc++;
                    w_tc_at = w_nv;
                end
                w_nv++;
            end
            prev_v = addr_valid;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(hold_req == 1'b0, "R12", "hold_req after reset", hold_req, 0);
        chk(dack == 4'b0, "R12", "dack after reset", dack, 0);
        chk(tc_status == 4'b0, "R12", "tc_status after reset", tc_status, 0);
        chk(mask_q == 4'hF, "R12", "mask after reset", mask_q, 4'hF);
    endtask

    // Byte channel 0, three transfers across a 64K wrap, device to memory.
    task automatic t_byte_wrap;
        load_ch(2'd0, 8'h12, 16'hFFFE, 16'd2, 2'b01);
        write_mask(4'b1110);
        hold_ack = 1'b1;
        dreq = 4'b0001;
        run_window(30);
        dreq = 4'b0000;
        chk(w_nv == 3, "R1", "byte transfer count", w_nv, 3);
        chk(w_addr[0] == byte_phys(8'h12, 16'hFFFE), "R2", "byte addr 0", w_addr[0], byte_phys(8'h12, 16'hFFFE));
        chk(w_addr[1] == byte_phys(8'h12, 16'hFFFF), "R2", "byte addr 1", w_addr[1], byte_phys(8'h12, 16'hFFFF));
        chk(w_addr[2] == 24'h120000, "R4", "byte wrap keeps page", w_addr[2], 24'h120000);
        chk(w_mw[0] == 1'b1, "R6", "kind 01 writes memory", w_mw[0], 1);
        chk(w_dack[0] == 4'b0001, "R5", "dack on channel 0", w_dack[0], 1);
        chk(!w_adjacent, "R5", "hold_req drops between transfers", w_adjacent, 0);
        chk(w_ntc == 1 && w_tc_at == 2, "R10", "tc on last transfer", w_tc_at, 2);
        chk(tc_status[0] == 1'b1, "R10", "tc_status bit 0", tc_status[0], 1);
        chk(mask_q[0] == 1'b1, "R10", "mask set at tc", mask_q[0], 1);
        load_ch(2'd0, 8'h00, 16'h0000, 16'd0, 2'b01);
        @(negedge clk);
        chk(tc_status[0] == 1'b0, "R10", "load clears tc_status", tc_status[0], 0);
    endtask

    // Word channel 2, two transfers across a 128K wrap, memory to device.
    task automatic t_word_wrap;
        load_ch(2'd2, 8'h35, 16'hFFFF, 16'd1, 2'b10);
        write_mask(4'b1011);
        dreq = 4'b0100;
        run_window(25);
        dreq = 4'b0000;
        chk(w_nv == 2, "R1", "word transfer count", w_nv, 2);
        chk(w_addr[0] == word_phys(8'h35, 16'hFFFF), "R3", "word addr 0", w_addr[0], word_phys(8'h35, 16'hFFFF));
        chk(w_addr[1] == 24'h340000, "R4", "word wrap keeps page", w_addr[1], 24'h340000);
        chk(w_mw[0] == 1'b0, "R6", "kind 10 reads memory", w_mw[0], 0);
    endtask

    // Masked channel 1 asks but is never served.
    task automatic t_masked;
        load_ch(2'd1, 8'h40, 16'h1000, 16'd3, 2'b01);
        write_mask(4'b1111);
        dreq = 4'b0010;
        run_window(15);
        dreq = 4'b0000;
        chk(w_nv == 0, "R7", "no transfer when masked", w_nv, 0);
        chk(!w_saw_req, "R7", "no hold_req when masked", w_saw_req, 0);
    endtask

    // Channels 0 and 1 request together, one transfer each.
    task automatic t_priority;
        load_ch(2'd0, 8'h01, 16'h0100, 16'd0, 2'b01);
        load_ch(2'd1, 8'h02, 16'h0200, 16'd0, 2'b01);
        write_mask(4'b1100);
        dreq = 4'b0011;
        run_window(20);
        dreq = 4'b0000;
        chk(w_nv == 2, "R1", "count 0 gives one transfer each", w_nv, 2);
        chk(w_dack[0] == 4'b0001, "R9", "lowest channel first", w_dack[0], 1);
        chk(w_dack[1] == 4'b0010, "R9", "then channel 1", w_dack[1], 2);
        chk(w_addr[1] == 24'h020200, "R2", "channel 1 address", w_addr[1], 24'h020200);
    endtask

    // Grant withheld: request up, no acknowledge, then one transfer.
    task automatic t_grant_wait;
        load_ch(2'd0, 8'h07, 16'h0070, 16'd0, 2'b10);
        write_mask(4'b1110);
        hold_ack = 1'b0;
        dreq = 4'b0001;
        run_window(10);
        chk(w_saw_req, "R11", "hold_req raised", w_saw_req, 1);
        chk(w_nv == 0, "R11", "no transfer without grant", w_nv, 0);
        chk(dack == 4'b0, "R11", "no dack without grant", dack, 0);
        hold_ack = 1'b1;
        run_window(10);
        dreq = 4'b0000;
        chk(w_nv == 1, "R5", "one transfer after grant", w_nv, 1);
        chk(w_addr[0] == 24'h070070, "R2", "granted address", w_addr[0], 24'h070070);
    endtask

    // Cascade channel 3 forwards request and grant only.
    task automatic t_cascade;
        load_ch(2'd3, 8'h55, 16'h5555, 16'd9, 2'b11);
        write_mask(4'b0111);
        hold_ack = 1'b0;
        dreq = 4'b1000;
        @(negedge clk);
        @(negedge clk);
        chk(hold_req == 1'b1, "R8", "cascade forwards request", hold_req, 1);
        chk(dack == 4'b0, "R8", "cascade dack waits for grant", dack, 0);
        hold_ack = 1'b1;
        #1;
        chk(dack == 4'b1000, "R8", "cascade dack follows grant", dack, 4'b1000);
        chk(addr_valid == 1'b0, "R8", "cascade drives no address", addr_valid, 0);
        @(negedge clk);
        dreq = 4'b0000;
        #1;
        chk(hold_req == 1'b0, "R8", "cascade request drops", hold_req, 0);
        @(negedge clk);
        chk(dack == 4'b0, "R8", "cascade dack drops", dack, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_byte_wrap();
        t_word_wrap();
        t_masked();
        t_priority();
        t_grant_wait();
        t_cascade();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule